// File: doc/BRIEF.md
# Multi-Format Stereo PCM Serial Receiver

The block turns a three-wire stereo audio stream into parallel samples. The stream is a bit clock, a frame clock that marks the left and right halves of each frame, and one data line. All three wires, plus the converter's master clock, are sampled in the system clock domain. Each one passes through a two-stage synchroniser. A bit-clock rising edge is then detected from the synchronised level, so the bit clock has to be several times slower than the system clock.

A 3-bit configuration code selects one of five framings:
- three right-justified word lengths (16, 20 and 24 bits);
- a 24-bit left-justified layout;
- a 24-bit I2S layout.

Every word is MSB first and two's complement. Words shorter than 24 bits are widened with zero low bits. When both halves of a frame have been taken, the left and right outputs update together and a one-cycle strobe is raised.

A separate watchdog per clock (master, bit, frame) counts system cycles since that clock's last edge. If any count runs out, the block reports that the clocks are not healthy. It then holds zero on both outputs and discards any partial frame. It reports again only after a fresh, complete frame has arrived.

Top module: `pcm_serial_rx`

## Requirements
- R1: With `fmt_sel` = 3'b010, the MSB of each channel is the bit sampled on the first bit-clock rise after the frame-clock edge, 24 bits are taken, and the half with `frame_clk` = 1 is the left channel.
- R2: With `fmt_sel` = 3'b011, the MSB is sampled on the second bit-clock rise after the frame-clock edge, 24 bits are taken, and the half with `frame_clk` = 0 is the left channel.
- R3: With `fmt_sel` = 3'b000 (16 bits), 3'b001 (20 bits) or 3'b100 (24 bits), the LSB is the bit sampled on the last bit-clock rise of the half, and all earlier bits are ignored. `frame_clk` = 1 marks the left half. The 16-bit code works with 16 bit clocks per half.
- R4: A 16-bit word appears on the 24-bit output as word<<8, and a 20-bit word as word<<4. The low bits are zero.
- R5: In the 3'b010 and 3'b011 codes, bits after the 24-bit word are ignored. Every code works with 32 bit clocks per half.
- R6: `left_smp` and `right_smp` change together, only in the cycle where `pair_valid` is high. `pair_valid` is a single-cycle pulse, issued once per completed left-then-right frame.
- R7: If any of `mclk`, `bit_clk` or `frame_clk` shows no edge for `STOP_LIMIT` system cycles, then `clocks_ok` goes low, both outputs become zero, and no pulse is issued. This lasts until all three clocks toggle again.
- R8: After reset, `left_smp`, `right_smp`, `pair_valid` and `clocks_ok` are all 0.
- R9: After reset, or after a clock stop, no pair is reported until a complete left half has been seen. A partial first frame is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk | input | 1 | Converter master clock, watched for activity only |
| bit_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| frame_clk | input | 1 | Frame clock marking left and right halves |
| ser_data | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Framing code (see R1 to R3) |
| left_smp | output | SMP_W | Left sample, left-aligned two's complement |
| right_smp | output | SMP_W | Right sample, left-aligned two's complement |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |
| clocks_ok | output | 1 | High while all three clocks are toggling |

## Verification
The hardest condition to reach is a stop of the master clock alone while bit and frame clocks keep running. During that stop a frame may be complete without being reported. After resuming, the first half-frame must be dropped rather than paired.

The stimulus runs a steady left-justified stream and halts only the master clock at a frame boundary. It keeps sending frames for longer than the timeout, then restarts the clock one frame early. The scoreboard treats any strobe it did not expect as an error, and it checks that the outputs read zero while the clocks are stopped.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;
    typedef enum logic [2:0] {
        FMT_RJ16  = 3'b000,
        FMT_RJ20  = 3'b001,
        FMT_LJ24  = 3'b010,
        FMT_I2S24 = 3'b011,
        FMT_RJ24  = 3'b100
    } fmt_e;
endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = din;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.stable;
endmodule

// File: rtl/pcmrx_stop_watch.sv
module pcmrx_stop_watch #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic stopped_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] idle;
        logic          stopped;
    } watch_t;

    watch_t s_d, s_q;
    logic   toggled;

    always_comb begin
        toggled = lvl ^ s_q.prev;
        s_d      = s_q;
        s_d.prev = lvl;
        if (toggled) begin
            s_d.idle    = '0;
            s_d.stopped = 1'b0;
        end else if (s_q.idle == CW'(LIMIT)) begin
            s_d.stopped = 1'b1;
        end else begin
            s_d.idle = s_q.idle + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.prev    <= 1'b0;
            s_q.idle    <= CW'(LIMIT);
            s_q.stopped <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign stopped_o = s_q.stopped;

    // R7
    resume_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.stopped) |-> $past(lvl ^ s_q.prev));
endmodule

// File: rtl/pcmrx_deser.sv
module pcmrx_deser
    import pcmrx_pkg::*;
#(
    parameter int W     = 24,
    parameter int CNT_W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_lvl,
    input  logic         lr_lvl,
    input  logic         sd_lvl,
    input  logic         clk_ok,
    input  logic [2:0]   fmt,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o,
    output logic         pair_o
);
    localparam int LEN_SHORT = W - 8;
    localparam int LEN_MID   = W - 4;
    localparam int CNT_MAX   = (1 << CNT_W) - 1;

    typedef struct packed {
        logic             bclk_prev;
        logic             primed;
        logic             started;
        logic             lr_prev;
        logic             have_left;
        logic [CNT_W-1:0] slot;
        logic [W-1:0]     shreg;
        logic [W-1:0]     pend_l;
        logic [W-1:0]     out_l;
        logic [W-1:0]     out_r;
        logic             pv;
    } rx_t;

    rx_t              s_d, s_q;
    fmt_e             mode;
    logic             rj, i2s, rise, chg, prev_left, take;
    int               wlen, off;
    logic [CNT_W-1:0] cur;
    logic [W-1:0]     word, base;

    always_comb begin
        mode = fmt_e'(fmt);
        rj   = (mode == FMT_RJ16) || (mode == FMT_RJ20) || (mode == FMT_RJ24);
        i2s  = (mode == FMT_I2S24);
        case (mode)
            FMT_RJ16: wlen = LEN_SHORT;
            FMT_RJ20: wlen = LEN_MID;
            default:  wlen = W;
        endcase
        off       = i2s ? 1 : 0;
        word      = rj ? (s_q.shreg << (W - wlen)) : s_q.shreg;
        rise      = bclk_lvl & ~s_q.bclk_prev;
        chg       = s_q.primed && (lr_lvl != s_q.lr_prev);
        prev_left = i2s ? ~s_q.lr_prev : s_q.lr_prev;
        cur       = chg ? '0 : s_q.slot;
        take      = rj || ((int'(cur) >= off) && (int'(cur) < off + W));
        base      = chg ? '0 : s_q.shreg;

        s_d           = s_q;
        s_d.pv        = 1'b0;
        s_d.bclk_prev = bclk_lvl;

        if (!clk_ok) begin
            s_d.primed    = 1'b0;
            s_d.started   = 1'b0;
            s_d.have_left = 1'b0;
            s_d.slot      = '0;
            s_d.out_l     = '0;
            s_d.out_r     = '0;
        end else if (rise) begin
            s_d.primed  = 1'b1;
            s_d.lr_prev = lr_lvl;
            if (chg) begin
                s_d.started = 1'b1;
                if (s_q.started) begin
                    if (prev_left) begin
                        s_d.pend_l    = word;
                        s_d.have_left = 1'b1;
                    end else if (s_q.have_left) begin
                        s_d.out_l     = s_q.pend_l;
                        s_d.out_r     = word;
                        s_d.pv        = 1'b1;
                        s_d.have_left = 1'b0;
                    end
                end
            end
            s_d.shreg = take ? {base[W-2:0], sd_lvl} : base;
            s_d.slot  = (cur == CNT_W'(CNT_MAX)) ? cur : cur + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign left_o  = s_q.out_l;
    assign right_o = s_q.out_r;
    assign pair_o  = s_q.pv;

    // R6
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pv |=> !s_q.pv);

    // R6
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.pv && $past(clk_ok)) |-> ($stable(s_q.out_l) && $stable(s_q.out_r)));

    // R7
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ok |=> (s_q.out_l == '0 && s_q.out_r == '0 && !s_q.pv));
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
    parameter int SMP_W      = 24,
    parameter int STOP_LIMIT = 1024,
    parameter int SLOT_CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk,
    input  logic             bit_clk,
    input  logic             frame_clk,
    input  logic             ser_data,
    input  logic [2:0]       fmt_sel,
    output logic [SMP_W-1:0] left_smp,
    output logic [SMP_W-1:0] right_smp,
    output logic             pair_valid,
    output logic             clocks_ok
);
    localparam int N_IN    = 4;
    localparam int N_WATCH = 3;

    logic [N_IN-1:0]    raw_in, synced;
    logic [N_WATCH-1:0] stopped;

    assign raw_in = {mclk, bit_clk, frame_clk, ser_data};

    pcmrx_sync #(.N(N_IN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (synced)
    );

    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
        pcmrx_stop_watch #(.LIMIT(STOP_LIMIT)) u_watch (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (synced[g+1]),
            .stopped_o(stopped[g])
        );
    end

    assign clocks_ok = ~|stopped;

    pcmrx_deser #(.W(SMP_W), .CNT_W(SLOT_CNT_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_lvl(synced[2]),
        .lr_lvl  (synced[1]),
        .sd_lvl  (synced[0]),
        .clk_ok  (clocks_ok),
        .fmt     (fmt_sel),
        .left_o  (left_smp),
        .right_o (right_smp),
        .pair_o  (pair_valid)
    );
endmodule

// File: tb/pcm_serial_rx_tb.sv
`timescale 1ns/1ps
module pcm_serial_rx_tb;
    localparam int STOP = 320;

    logic        clk = 0, rst_n = 0, mclk = 0, bclk = 1, lrck = 0, sdat = 0;
    logic        mclk_run = 1;
    logic [2:0]  fmt = 3'b010;
    logic [23:0] left_smp, right_smp;
    logic        pair_valid, clocks_ok;
    int          checks = 0, errors = 0;
    bit          done = 0;
    logic [23:0] q_l[$], q_r[$];
    string       q_tag[$];

    pcm_serial_rx #(.STOP_LIMIT(STOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .mclk(mclk), .bit_clk(bclk), .frame_clk(lrck),
        .ser_data(sdat), .fmt_sel(fmt), .left_smp(left_smp), .right_smp(right_smp),
        .pair_valid(pair_valid), .clocks_ok(clocks_ok)
    );

    always #4 clk = ~clk;

    always begin
        repeat (3) @(negedge clk);
        if (mclk_run) mclk = ~mclk;
    end

    task automatic chk(bit ok, string req, string what, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] align(logic [2:0] f, logic [23:0] w);
        case (f)
            3'b000:  return {w[15:0], 8'h00};
            3'b001:  return {w[19:0], 4'h0};
            default: return w;
        endcase
    endfunction

    function automatic logic slot_bit(logic [2:0] f, int bpc, logic [23:0] w, int s);
        int n;
        case (f)
            3'b010:  return (s < 24) ? w[23-s] : 1'b1;
            3'b011:  return (s >= 1 && s <= 24) ? w[24-s] : 1'b1;
            default: begin
                n = (f == 3'b000) ? 16 : (f == 3'b001) ? 20 : 24;
                return (s >= bpc - n) ? w[bpc-1-s] : 1'b1;
            end
        endcase
    endfunction

    task automatic put_bit(logic lv, logic b);
        bclk = 0; lrck = lv; sdat = b;
        repeat (4) @(negedge clk);
        bclk = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(logic [2:0] f, int bpc, logic [23:0] lv, logic [23:0] rv,
                              bit expect_it, string tag);
        logic lh;
        lh = (f == 3'b011) ? 1'b0 : 1'b1;
        for (int s = 0; s < bpc; s++) put_bit(lh, slot_bit(f, bpc, lv, s));
        for (int s = 0; s < bpc; s++) put_bit(~lh, slot_bit(f, bpc, rv, s));
        if (expect_it) begin
            q_l.push_back(align(f, lv));
            q_r.push_back(align(f, rv));
            q_tag.push_back(tag);
        end
    endtask

    task automatic idle_check(string tag);
        repeat (STOP + 100) @(negedge clk);
        chk(clocks_ok == 1'b0, "R7", {tag, " clocks_ok after stop"}, 24'(clocks_ok), 24'h0);
        chk(left_smp == 24'h0 && right_smp == 24'h0, "R7", {tag, " zero outputs"},
            left_smp | right_smp, 24'h0);
    endtask

    task automatic run_seq(logic [2:0] f, int bpc, int n, string tag);
        logic [23:0] lv, rv;
        fmt = f;
        send_frame(f, bpc, 24'h123456, 24'h654321, 0, tag);
        for (int i = 0; i < n; i++) begin
            lv = (i == 0) ? 24'h800001 : (i == 1) ? 24'h7FFFFE : 24'($urandom);
            rv = (i == 0) ? 24'h7FFF00 : 24'($urandom);
            send_frame(f, bpc, lv, rv, 1, tag);
        end
        send_frame(f, bpc, 24'hABCDEF, 24'hFEDCBA, 0, tag);
        idle_check(tag);
    endtask

    // Scoreboard monitor
    logic pv_prev = 0;
    always @(negedge clk) begin : mon
        logic [23:0] el, er;
        string t;
        if (rst_n && pair_valid) begin
            if (pv_prev) begin
                checks++; errors++;
                $display("FAIL R6 strobe wider than one cycle actual=%h expected=%h", 24'h1, 24'h0);
            end
            if (q_l.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected pair actual=%h expected=%h", left_smp, 24'h0);
            end else begin
                el = q_l.pop_front(); er = q_r.pop_front(); t = q_tag.pop_front();
                chk(left_smp == el, t, "left sample", left_smp, el);
                chk(right_smp == er, t, "right sample", right_smp, er);
            end
        end
        pv_prev = pair_valid;
    end

    initial begin : wdog
        repeat (200000) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R6 watchdog actual=%h expected=%h", 24'h0, 24'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(left_smp == 24'h0, "R8", "reset left", left_smp, 24'h0);
        chk(right_smp == 24'h0, "R8", "reset right", right_smp, 24'h0);
        chk(pair_valid == 1'b0, "R8", "reset strobe", 24'(pair_valid), 24'h0);
        chk(clocks_ok == 1'b0, "R8", "reset clocks_ok", 24'(clocks_ok), 24'h0);

        run_seq(3'b010, 32, 3, "R1_R5");
        run_seq(3'b010, 24, 2, "R1");
        run_seq(3'b011, 32, 3, "R2_R5");
        run_seq(3'b000, 16, 2, "R3_R4");
        run_seq(3'b000, 32, 2, "R4_R5");
        run_seq(3'b001, 32, 2, "R3_R4");
        run_seq(3'b100, 32, 2, "R3_R5");
        run_seq(3'b100, 24, 2, "R3");

        // R7 and R9: master clock alone stops while the stream keeps running
        fmt = 3'b010;
        send_frame(3'b010, 32, 24'h111111, 24'h222222, 0, "R9");
        send_frame(3'b010, 32, 24'h345678, 24'h876543, 1, "R7");
        mclk_run = 0;
        send_frame(3'b010, 32, 24'h0F0F0F, 24'hF0F0F0, 0, "R7");
        send_frame(3'b010, 32, 24'h0E0E0E, 24'hE0E0E0, 0, "R7");
        chk(clocks_ok == 1'b0, "R7", "master clock stop", 24'(clocks_ok), 24'h0);
        chk(left_smp == 24'h0 && right_smp == 24'h0, "R7", "zero during stop",
            left_smp | right_smp, 24'h0);
        mclk_run = 1;
        send_frame(3'b010, 32, 24'h5A5A5A, 24'hA5A5A5, 0, "R9");
        send_frame(3'b010, 32, 24'h13579B, 24'h2468AC, 1, "R9");
        send_frame(3'b010, 32, 24'hC0FFEE, 24'hBEEF00, 0, "R9");
        chk(clocks_ok == 1'b1, "R7", "clocks resumed", 24'(clocks_ok), 24'h1);
        idle_check("R7");

        chk(q_l.size() == 0, "R6", "pairs outstanding", 24'(q_l.size()), 24'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule